// File: doc/BRIEF.md
# Multi-channel prescaled down-counter timer

This unit holds up to three identical down-counting channels, all reached over one simple register bus: address, write strobe, write data and a combinational read data path. Each channel has a reload value, a live counter and a control register. The control register picks a divider for the clock, enables the underflow interrupt and holds a sticky underflow flag. A shared start register runs or halts each channel on its own.

A free-running divider makes one single-cycle tick for each division ratio. A running channel counts down once per selected tick. When a tick arrives with the counter at zero, the counter loads the reload value instead of wrapping, and the channel's flag is set. Each channel drives a level interrupt output, which is high while both its flag and its interrupt enable are set. Software clears the flag by writing the control register with bit 8 at zero.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every reload register and every counter read 0xFFFFFFFF, every control register and the start register read 0, and every interrupt output is low.
- R2: The register groups of channels 0, 1 and 2 start at byte addresses 0x08, 0x14 and 0x20. In each group the reload value is at +0x0, the counter at +0x4 and the control register at +0x8. A write to the reload value or to the counter takes effect at once, whether or not the channel runs.
- R3: Control bits [2:0] choose the prescaler. Codes 0, 1, 2, 3 and 4 give one count every 4, 16, 64, 256 and 1024 clocks. Codes 5 to 7 behave like code 0. The divider runs freely from the end of reset.
- R4: When a running channel gets a tick with its counter at zero, the counter loads the reload value and counting goes on. Successive underflows are therefore (reload + 1) × divide clocks apart.
- R5: An underflow sets the flag, which reads back in control bit 8. Control bit 5 enables the interrupt. The interrupt output is high exactly when both bits are set.
- R6: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag as it is, so software can never set it.
- R7: If an underflow and a control write that clears the flag fall in the same cycle, the flag ends up set.
- R8: Only control bits [2:0], 5 and 8 hold state. All other control bits, including the reserved bits [15:10], read as 0. Start register bits above the channel count read as 0.
- R9: The start register is at byte address 0x04, and bit n runs channel n. A halted channel's counter keeps its value, and channels start and stop independently of each other.
- R10: A read of an address that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 3 | Level interrupt, one per channel |

## Verification
A channel's own underflow and a software write that clears its flag can land on the same clock edge. To provoke this, the bench lets a channel underflow once, clears the flag, and then times a second clear so that it is applied on exactly the edge of the next underflow, (reload + 1) × 4 clocks later. The result is judged at the ports: the interrupt must still be high after that edge and the flag must read as set. A further clear one cycle later must then take effect.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the prescaled down-counter timer.
// Assumes byte addressing on a 32-bit register bus.
package tmr_pkg;
    localparam int NUM_DIV    = 5;   // divide ratios 4^1 .. 4^5
    localparam int PSC_W      = 3;   // prescaler code width
    localparam int CTL_UIE    = 5;   // interrupt enable bit
    localparam int CTL_UNF    = 8;   // underflow flag bit
    localparam int START_ADR  = 4;   // start register address
    localparam int GRP_BASE   = 8;   // first channel group
    localparam int GRP_STRIDE = 12;  // bytes per channel group
    localparam int OFS_RELOAD = 0;
    localparam int OFS_COUNT  = 4;
    localparam int OFS_CTL    = 8;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             uie;
    } ctl_t;
endpackage

// File: rtl/tmr_prescale.sv
// Free-running clock divider. Emits a one-cycle tick for each ratio
// 4^(k+1), k = 0..NUM_DIV-1. Assumes the consumer samples the ticks
// as clock enables in the same domain.
module tmr_prescale #(
    parameter int NUM_DIV = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_DIV-1:0] tick
);
    localparam int DIV_W = 2 * NUM_DIV;

    logic [DIV_W-1:0] div_q;

    // Advance the divider on every clock once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tick per ratio: the low 2(k+1) bits are all ones.
    for (genvar k = 0; k < NUM_DIV; k++) begin : g_tick
        assign tick[k] = &div_q[2*k+1:0];
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: reload register, down counter, control fields and
// sticky underflow flag. Assumes at most one write strobe is active per
// cycle, all driven by the bus decoder.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_DIV-1:0] tick,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_reload,
    input  logic               wr_count,
    input  logic               wr_ctl,
    output logic [CNT_W-1:0]   reload_q,
    output logic [CNT_W-1:0]   count_q,
    output ctl_t               ctl_q,
    output logic               flag_q,
    output logic               uf_evt,
    output logic               irq
);
    logic step;

    // Pick the tick for the programmed code; codes past the last ratio use the first.
    always_comb begin
        step = tick[0];
        for (int k = 1; k < NUM_DIV; k++) begin
            if (ctl_q.psc == PSC_W'(k)) step = tick[k];
        end
    end

    // Underflow: a counted tick while at zero, unless software writes the counter.
    assign uf_evt = run && step && (count_q == '0) && !wr_count;

    // Reload register, written straight from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '1;
        else if (wr_reload) reload_q <= wdata[CNT_W-1:0];
    end

    // Counter: a bus write wins, otherwise count down or reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '1;
        else if (wr_count)       count_q <= wdata[CNT_W-1:0];
        else if (run && step)    count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
    end

    // Control fields that hold state.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= '{psc: wdata[PSC_W-1:0], uie: wdata[CTL_UIE]};
    end

    // Sticky flag: set by underflow, cleared by a zero write; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= uf_evt || (flag_q && !(wr_ctl && !wdata[CTL_UNF]));
    end

    assign irq = flag_q && ctl_q.uie;
endmodule

// File: rtl/tmr_unit.sv
// Timer unit top: bus decoder, start register, read multiplexer and
// NUM_CH channels sharing one prescaler. Assumes ADDR_W wide enough to
// hold every group address and CNT_W no wider than DATA_W.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_DIV-1:0]             tick;
    logic [NUM_CH-1:0]              start_q;
    logic [NUM_CH-1:0][CNT_W-1:0]   reload_a;
    logic [NUM_CH-1:0][CNT_W-1:0]   count_a;
    ctl_t [NUM_CH-1:0]              ctl_a;
    logic [NUM_CH-1:0]              flag_a;
    logic [NUM_CH-1:0]              uf_a;
    logic [NUM_CH-1:0]              wr_reload_a;
    logic [NUM_CH-1:0]              wr_count_a;
    logic [NUM_CH-1:0]              wr_ctl_a;

    tmr_prescale #(.NUM_DIV(NUM_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Start register: one run bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (bus_we && bus_addr == ADDR_W'(START_ADR))
            start_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = GRP_BASE + GRP_STRIDE * i;

        assign wr_reload_a[i] = bus_we && bus_addr == ADDR_W'(BASE + OFS_RELOAD);
        assign wr_count_a[i]  = bus_we && bus_addr == ADDR_W'(BASE + OFS_COUNT);
        assign wr_ctl_a[i]    = bus_we && bus_addr == ADDR_W'(BASE + OFS_CTL);

        tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (start_q[i]),
            .tick      (tick),
            .wdata     (bus_wdata),
            .wr_reload (wr_reload_a[i]),
            .wr_count  (wr_count_a[i]),
            .wr_ctl    (wr_ctl_a[i]),
            .reload_q  (reload_a[i]),
            .count_q   (count_a[i]),
            .ctl_q     (ctl_a[i]),
            .flag_q    (flag_a[i]),
            .uf_evt    (uf_a[i]),
            .irq       (irq_o[i])
        );
    end

    // Read multiplexer: unmapped addresses and unheld bits return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(START_ADR))
            bus_rdata[NUM_CH-1:0] = start_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(GRP_BASE + GRP_STRIDE * i + OFS_RELOAD))
                bus_rdata = DATA_W'(reload_a[i]);
            if (bus_addr == ADDR_W'(GRP_BASE + GRP_STRIDE * i + OFS_COUNT))
                bus_rdata = DATA_W'(count_a[i]);
            if (bus_addr == ADDR_W'(GRP_BASE + GRP_STRIDE * i + OFS_CTL)) begin
                bus_rdata[PSC_W-1:0] = ctl_a[i].psc;
                bus_rdata[CTL_UIE]   = ctl_a[i].uie;
                bus_rdata[CTL_UNF]   = flag_a[i];
            end
        end
    end
endmodule

// File: rtl/tmr_unit_chk.sv
// Property checker for tmr_unit, bound to every instance of the top.
// Assumes the per-channel vectors are indexed by channel number.
module tmr_unit_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CH-1:0]              run,
    input logic [NUM_CH-1:0]              uf,
    input logic [NUM_CH-1:0]              flag,
    input logic [NUM_CH-1:0]              wr_ctl,
    input logic [NUM_CH-1:0]              wr_count,
    input logic [NUM_CH-1:0]              irq,
    input logic [NUM_CH-1:0][CNT_W-1:0]   count,
    input logic [NUM_CH-1:0][CNT_W-1:0]   reload
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        // R4
        reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uf[i] |=> count[i] == $past(reload[i]));
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            uf[i] |=> flag[i]);
        // R6
        no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag[i] && !uf[i]) |=> !flag[i]);
        // R9
        halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !wr_count[i]) |=> $stable(count[i]));
        // R5
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(uf[i]) || $past(wr_ctl[i])));
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (start_q),
    .uf       (uf_a),
    .flag     (flag_a),
    .wr_ctl   (wr_ctl_a),
    .wr_count (wr_count_a),
    .irq      (irq_o),
    .count    (count_a),
    .reload   (reload_a)
);

// File: tb/tmr_unit_test.sv
`timescale 1ns/1ps
// Directed bench for tmr_unit: one task per scenario, each checking itself.
module tmr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tmr_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] ga(input int ch, input int ofs);
        return 8'(8 + 12 * ch + ofs);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called just after a negedge; the write lands on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 3; c++) begin
            rd(ga(c, 0), v); chk("R1 reload reset", v, 32'hFFFF_FFFF);
            rd(ga(c, 4), v); chk("R1 count reset", v, 32'hFFFF_FFFF);
            rd(ga(c, 8), v); chk("R1 ctl reset", v, 32'h0);
        end
        rd(8'h04, v); chk("R1 start reset", v, 32'h0);
        chk("R1 irq reset", {29'h0, irq_o}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(ga(1, 0), 32'h0000_1234);
        wr(ga(2, 4), 32'h0000_ABCD);
        rd(ga(1, 0), v); chk("R2 reload write", v, 32'h0000_1234);
        rd(ga(2, 4), v); chk("R2 count write", v, 32'h0000_ABCD);
        repeat (50) @(negedge clk);
        rd(ga(2, 4), v); chk("R9 halted count holds", v, 32'h0000_ABCD);
    endtask

    task automatic t_prescale();
        logic [31:0] c1, c2;
        int div;
        for (int code = 0; code < 6; code++) begin
            div = (code == 5) ? 4 : (4 << (2 * code));
            wr(ga(0, 8), 32'(code));
            wr(ga(0, 4), 32'hFFFF_0000);
            wr(8'h04, 32'h1);
            rd(ga(0, 4), c1);
            repeat (div * 3) @(negedge clk);
            rd(ga(0, 4), c2);
            chk($sformatf("R3 counts in %0d clocks, code %0d", div * 3, code), c1 - c2, 32'd3);
            wr(8'h04, 32'h0);
        end
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        int gap = 0;
        wr(ga(1, 0), 32'd3);
        wr(ga(1, 4), 32'd0);
        wr(ga(1, 8), 32'h20);
        wr(8'h04, 32'h2);
        while (!irq_o[1] && gap < 200) begin @(negedge clk); gap++; end
        rd(ga(1, 4), v); chk("R4 reload after underflow", v, 32'd3);
        rd(ga(1, 8), v); chk("R5 flag and enable read", v, 32'h120);
        wr(ga(1, 8), 32'h20);
        chk("R6 zero write clears irq", {31'h0, irq_o[1]}, 32'h0);
        gap = 1;
        while (!irq_o[1] && gap < 200) begin @(negedge clk); gap++; end
        chk("R4 underflow period", 32'(gap), 32'd16);
        wr(ga(1, 8), 32'h00);
        repeat (40) @(negedge clk);
        chk("R5 irq low without enable", {31'h0, irq_o[1]}, 32'h0);
        rd(ga(1, 8), v); chk("R5 flag set without enable", v, 32'h100);
        wr(8'h04, 32'h0);
        wr(ga(1, 8), 32'h120);
        chk("R5 irq once enabled", {31'h0, irq_o[1]}, 32'h1);
        wr(ga(1, 8), 32'h000);
        wr(ga(1, 8), 32'h120);
        rd(ga(1, 8), v); chk("R6 software cannot set flag", v, 32'h020);
        chk("R6 irq stays low", {31'h0, irq_o[1]}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        int gap = 0;
        wr(ga(0, 0), 32'd3);
        wr(ga(0, 4), 32'd0);
        wr(ga(0, 8), 32'h20);
        wr(8'h04, 32'h1);
        while (!irq_o[0] && gap < 200) begin @(negedge clk); gap++; end
        wr(ga(0, 8), 32'h20);                // clear, one cycle after the underflow
        repeat (14) @(negedge clk);          // to the negedge before the next underflow
        wr(ga(0, 8), 32'h20);                // clear lands on the underflow edge
        chk("R7 set wins irq", {31'h0, irq_o[0]}, 32'h1);
        rd(ga(0, 8), v); chk("R7 set wins flag", v, 32'h120);
        wr(ga(0, 8), 32'h20);
        chk("R6 later clear works", {31'h0, irq_o[0]}, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_start();
        logic [31:0] v, x;
        wr(ga(0, 8), 32'h0);
        wr(ga(2, 8), 32'h0);
        wr(ga(0, 4), 32'd1000);
        wr(ga(2, 4), 32'd1000);
        wr(8'h04, 32'h4);
        rd(8'h04, v); chk("R9 start readback", v, 32'h4);
        repeat (40) @(negedge clk);
        rd(ga(0, 4), v); chk("R9 halted channel 0 holds", v, 32'd1000);
        rd(ga(2, 4), v); chk("R9 running channel 2 counts", 32'(v < 32'd1000), 32'd1);
        wr(8'h04, 32'h0);
        rd(ga(2, 4), x);
        repeat (40) @(negedge clk);
        rd(ga(2, 4), v); chk("R9 stopped channel 2 holds", v, x);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(ga(2, 8), 32'h0000_FCFF);
        rd(ga(2, 8), v); chk("R8 unheld control bits read 0", v, 32'h27);
        wr(8'h04, 32'hFF);
        rd(8'h04, v); chk("R8 start upper bits read 0", v, 32'h7);
        wr(8'h04, 32'h0);
        rd(8'h00, v); chk("R10 address 0x00", v, 32'h0);
        rd(8'h2C, v); chk("R10 address 0x2C", v, 32'h0);
        rd(8'hFC, v); chk("R10 address 0xFC", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_prescale();
        t_underflow();
        t_same_cycle();
        t_start();
        t_map();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule